// File: doc/BRIEF.md
# Reset Cause and Soft Reset Control Register

This block holds one 32-bit register that tells software why the system last came out of reset, and gives software a way to ask for a new reset. Five cause flags sit in the top five bits. The power-on flag is set only on the first system reset after power-up. Two button-event inputs set the button flags. Software clears the power-on and button flags by writing ones to them, and it sets the two soft flags by writing ones to them. Writing a soft flag also produces a one-cycle request on the system reset output. That request is passed to reset distribution logic outside this block.

A saturating counter of system resets decides whether a reset is the first one. The counter is cleared only by the power-up reset or by a soft power-on request. After a soft power-on request, the next system reset loads the register with only the power-on flag, just as after power-up. After a soft warm-reset request the counter is left alone, so the next system reset keeps the register contents.

The register sits in an 8-byte window of a simple register bus. Only the upper word of the window (address bit 2 set) carries data. Read data is registered.

Top module: `rst_cause_ctl`

## Requirements
- R1: While `pwr_rst` is high, the register is cleared, the counter is cleared, and `bus_rdata` and `sys_rst_req` are driven low.
- R2: A `sys_rst` cycle with the counter at zero loads the register with exactly 0x80000000 (only bit 31, the power-on flag).
- R3: A `sys_rst` cycle with the counter above zero leaves the register unchanged. Every `sys_rst` cycle adds one to the counter.
- R4: Bits 31, 28 and 27 are write-one-to-clear. Writing a zero to any of them leaves that bit unchanged.
- R5: Bits 30 (soft power-on) and 29 (soft warm reset) are set by writing a one. No write clears them.
- R6: Bits 26:0 always read as zero, and writes to them are ignored.
- R7: A write with bit 30 set clears the counter. In the cycle after the write, `sys_rst_req` is high for exactly one cycle.
- R8: A write with bit 29 set and bit 30 clear pulses `sys_rst_req` for one cycle and leaves the counter unchanged. Writes with neither bit set never pulse `sys_rst_req`.
- R9: The counter stops at 2^CNT_W-1 and does not wrap. After the first reset, any number of further resets never reload the power-on flag.
- R10: The window covers BASE to BASE+7. An access reaches the register only when address bit 2 is set. Reads of the lower word, and reads outside the window, return zero; writes to either are ignored. Read data appears on `bus_rdata` in the cycle after the read request.
- R11: A high `btn_por_evt` sets bit 28, and a high `btn_xir_evt` sets bit 27. In the same cycle, a set from a button event wins over a write-one-to-clear of that bit. Both are ignored during `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous active-high power-up reset; clears the counter and the register |
| sys_rst | input | 1 | Synchronous active-high system reset event |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| btn_por_evt | input | 1 | Button power-on event; sets bit 28 |
| btn_xir_evt | input | 1 | Button warm-reset event; sets bit 27 |
| bus_rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle request for a system reset |

## Verification
The hardest condition to reach from the ports is the counter at its saturation value. Only the power-on flag shows this, and only when it would reappear after a counter wrap. To get there, the bench applies a power-up reset and one system reset, then clears the power-on flag. It then applies more system resets than the counter can count, and reads the register after every one of them. A second hard condition is a button set and a clear of the same bit in the same cycle; the bench gets there by driving the button input on the same edge as the clearing write. Every single-bit write pattern is swept, each one from a freshly restored state in which all three clearable flags are set.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int DATA_W = 32;
  localparam int B_POR  = 31;
  localparam int B_SPOR = 30;
  localparam int B_SXIR = 29;
  localparam int B_BPOR = 28;
  localparam int B_BXIR = 27;
  localparam logic [DATA_W-1:0] MASK_W1C  = 32'h9800_0000;
  localparam logic [DATA_W-1:0] MASK_SET  = 32'h6000_0000;
  localparam logic [DATA_W-1:0] MASK_LIVE = 32'hF800_0000;
  localparam logic [DATA_W-1:0] VAL_POR   = 32'h8000_0000;
endpackage

// File: rtl/rsc_decode.sv
module rsc_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic in_win;
  always_comb begin
    in_win = (addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
    wr_hit = sel && we && in_win && addr[2];
    rd_hit = sel && !we && in_win && addr[2];
  end
endmodule

// File: rtl/rsc_counter.sv
module rsc_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic pwr_rst,
  input  logic sys_rst,
  input  logic clr,
  output logic cnt_zero
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (pwr_rst)                 cnt <= '0;
    else if (sys_rst) begin
      if (cnt != CMAX)           cnt <= cnt + 1'b1;
    end
    else if (clr)                cnt <= '0;
  end

  assign cnt_zero = (cnt == '0);

  // R9: saturation holds the count at its ceiling
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (pwr_rst)
    (sys_rst && cnt == CMAX) |=> (cnt == CMAX));
  // R7: a clear request without system reset empties the counter
  p_clear_r7: assert property (@(posedge clk) disable iff (pwr_rst)
    (clr && !sys_rst) |=> cnt_zero);
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              sys_rst,
  input  logic              first,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              btn_por,
  input  logic              btn_xir,
  output logic [DATA_W-1:0] cause
);
  logic [DATA_W-1:0] wd, btn_set, nxt;

  always_comb begin
    wd = wr ? (wdata & MASK_LIVE) : '0;
    btn_set = '0;
    btn_set[B_BPOR] = btn_por;
    btn_set[B_BXIR] = btn_xir;
    nxt = (cause & ~(wd & MASK_W1C)) | (wd & MASK_SET) | btn_set;
  end

  always_ff @(posedge clk) begin
    if (pwr_rst)      cause <= '0;
    else if (sys_rst) begin
      if (first)      cause <= VAL_POR;
    end
    else              cause <= nxt;
  end

  p_first_load_r2: assert property (@(posedge clk) disable iff (pwr_rst)
    (sys_rst && first) |=> (cause == VAL_POR));
  p_keep_on_rst_r3: assert property (@(posedge clk) disable iff (pwr_rst)
    (sys_rst && !first) |=> (cause == $past(cause)));
  p_w1c_top_r4: assert property (@(posedge clk) disable iff (pwr_rst)
    (!sys_rst && wr && wdata[B_POR]) |=> !cause[B_POR]);
  p_soft_sticky_r5: assert property (@(posedge clk) disable iff (pwr_rst)
    (!sys_rst && cause[B_SPOR]) |=> cause[B_SPOR]);
  p_btn_set_r11: assert property (@(posedge clk) disable iff (pwr_rst)
    (!sys_rst && btn_por) |=> cause[B_BPOR]);
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              pwr_rst,
  input  logic              sys_rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              btn_por_evt,
  input  logic              btn_xir_evt,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_req
);
  logic wr_hit, rd_hit, cnt_zero, soft_por_wr, soft_any_wr;
  logic [DATA_W-1:0] cause;

  rsc_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  always_comb begin
    soft_por_wr = wr_hit && bus_wdata[B_SPOR];
    soft_any_wr = wr_hit && (bus_wdata[B_SPOR] || bus_wdata[B_SXIR]);
  end

  rsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .pwr_rst(pwr_rst), .sys_rst(sys_rst),
    .clr(soft_por_wr), .cnt_zero(cnt_zero)
  );

  rsc_cause u_cause (
    .clk(clk), .pwr_rst(pwr_rst), .sys_rst(sys_rst), .first(cnt_zero),
    .wr(wr_hit), .wdata(bus_wdata),
    .btn_por(btn_por_evt), .btn_xir(btn_xir_evt), .cause(cause)
  );

  always_ff @(posedge clk) begin
    if (pwr_rst || sys_rst) begin
      bus_rdata   <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      bus_rdata   <= rd_hit ? cause : '0;
      sys_rst_req <= soft_any_wr;
    end
  end

  // R8: a request only follows a write carrying a soft flag
  p_req_source_r8: assert property (@(posedge clk) disable iff (pwr_rst)
    sys_rst_req |-> $past(wr_hit && (bus_wdata[B_SPOR] || bus_wdata[B_SXIR])));
  // R10: no data-word read means zero read data next cycle
  p_rd_zero_r10: assert property (@(posedge clk) disable iff (pwr_rst)
    !rd_hit |=> (bus_rdata == '0));
  // R6: unused bits never show on the bus
  p_low_bits_r6: assert property (@(posedge clk) disable iff (pwr_rst)
    rd_hit |=> (bus_rdata[26:0] == '0));
endmodule

// File: tb/rst_cause_ctl_test.sv
`timescale 1ns/1ps
module rst_cause_ctl_test;
  localparam logic [15:0] BASE = 16'hF020;
  localparam int CMAX = 15;

  logic clk = 0, pwr_rst = 0, sys_rst = 0, bus_sel = 0, bus_we = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic btn_por_evt = 0, btn_xir_evt = 0;
  logic [31:0] bus_rdata;
  logic sys_rst_req;

  int checks = 0, fails = 0, m_cnt = 0;
  logic [31:0] m_reg = '0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_cause_ctl #(.ADDR_W(16), .BASE(BASE), .CNT_W(4)) uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_pwr();
    @(negedge clk); pwr_rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 req", {31'b0, sys_rst_req}, 0);
    pwr_rst = 0; m_reg = 0; m_cnt = 0;
  endtask

  task automatic do_rst();
    sys_rst = 1; @(negedge clk); sys_rst = 0;
    if (m_cnt == 0) m_reg = 32'h8000_0000;
    if (m_cnt < CMAX) m_cnt++;
  endtask

  task automatic do_rd(string tag, logic [15:0] a, logic [31:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic do_wr(string tag, logic [15:0] a, logic [31:0] d);
    logic hit; logic [31:0] wd;
    hit = (a[15:3] == BASE[15:3]) && a[2];
    wd = hit ? (d & 32'hF800_0000) : 0;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    m_reg = (m_reg & ~(wd & 32'h9800_0000)) | (wd & 32'h6000_0000);
    if (wd[30]) m_cnt = 0;
    chk({tag, " pulse"}, {31'b0, sys_rst_req}, {31'b0, wd[30] | wd[29]});
    @(negedge clk);
    chk({tag, " one-cycle"}, {31'b0, sys_rst_req}, 0);
  endtask

  task automatic buttons();
    btn_por_evt = 1; btn_xir_evt = 1; @(negedge clk);
    btn_por_evt = 0; btn_xir_evt = 0;
    m_reg = m_reg | 32'h1800_0000;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    do_pwr();
    do_rd("R1 reg after power-up", BASE + 4, 0);
    do_rst();
    do_rd("R2 first reset", BASE + 4, 32'h8000_0000);
    buttons();
    do_rd("R11 buttons", BASE + 4, m_reg);

    // single-bit sweep over R4 R5 R6 R7 R8
    for (int b = 0; b < 32; b++) begin
      do_rst(); buttons();
      do_wr("R4/R5/R6 sweep", BASE + 4, 32'h1 << b);
      do_rd("R4/R5/R6 sweep read", BASE + 4, m_reg);
    end
    do_wr("R4 write zero", BASE + 4, 0);
    do_rd("R4 zero write no change", BASE + 4, m_reg);

    // R10 decode
    do_rst(); buttons();
    do_wr("R10 lower word", BASE, 32'hFFFF_FFFF);
    do_wr("R10 outside", BASE + 8, 32'hFFFF_FFFF);
    do_rd("R10 lower word read", BASE, 0);
    do_rd("R10 outside read", BASE - 4, 0);
    do_rd("R10 data word intact", BASE + 4, m_reg);

    // R3 / R8 warm request keeps contents across reset
    do_pwr(); do_rst();
    do_wr("R8 soft warm", BASE + 4, 32'h2000_0000);
    do_rst();
    do_rd("R3 retained", BASE + 4, 32'hA000_0000);
    // R7 soft power-on re-arms first-reset load
    do_wr("R7 soft por", BASE + 4, 32'h8000_0000);
    do_wr("R7 soft por", BASE + 4, 32'h4000_0000);
    do_rst();
    do_rd("R7 por reload", BASE + 4, 32'h8000_0000);

    // R11 set beats clear
    bus_sel = 1; bus_we = 1; bus_addr = BASE + 4; bus_wdata = 32'h1800_0000;
    btn_por_evt = 1; @(negedge clk);
    bus_sel = 0; bus_we = 0; btn_por_evt = 0;
    do_rd("R11 set wins", BASE + 4, 32'h9000_0000);

    // R9 saturation
    do_pwr(); do_rst();
    do_wr("R9 clear por", BASE + 4, 32'h9800_0000);
    for (int i = 0; i < 2 * CMAX; i++) begin
      do_rst();
      do_rd("R9 no reload", BASE + 4, m_reg);
    end
    chk("R9 reg empty", m_reg, 0);

    done = 1;
    report();
  end
endmodule